// File: doc/BRIEF.md
# Mode-Routed Three-Channel Audio Mixer

This block is a streaming digital mixer with three outputs: a mono speaker feed and a left and a right headphone feed. On each cycle where the input strobe is high, it takes one sample from each of two stereo input pairs (A and B) and one sample from a mono input. A source selector builds the left and right stereo signals from these inputs. The choices are pair A, pair B, the sum of the two pairs, or the side-by-side difference A minus B.

The left, right and mono signals each pass through their own gain stage. Each stage is set by a 5-bit code that indexes a non-uniform decibel staircase, and the gain is applied as a fixed-point linear coefficient. A 3-bit mode code then routes and sums the gained signals to each output, or marks an output as muted or shut down. Every sum is formed at full width and clipped to the signed sample range.

All results, flags and the output strobe leave a single register stage. Settings are sampled together with the samples, so each output sample reflects exactly one set of settings.

Top module: `audio_route_mixer`

## Requirements
- R1: While reset is asserted and after it is released, until the first input strobe, every data output is 0, every shutdown flag is 1, every mute flag is 0 and `out_valid` is 0.
- R2: The data outputs and flags update in the cycle after the cycle in which `in_valid` is 1, and `out_valid` is 1 in exactly that cycle. With no strobe, outputs hold their values even if samples, selects, gains or mode change. Settings take effect only together with a strobed sample.
- R3: The stereo source is chosen per side by `diff_en`, `sel_a` and `sel_b`. If `diff_en` = 1, the source is A minus B and both selects are ignored. Otherwise: `sel_a`=1 and `sel_b`=0 gives A; `sel_a`=0 and `sel_b`=1 gives B; both 1 gives A+B; both 0 gives 0. The mono source is `in_mono`.
- R4: Gain code c maps to a dB value: c=0 is -59.5, c=1 is -48, c=2 is -40.5, c=3 is -34.5. Codes 4 to 9 run from -30 in +3 dB steps. Codes 10 to 31 run from -13.5 in +1.5 dB steps, so code 19 is 0 dB and code 31 is +18 dB. The coefficient is round(4096·10^(dB/20)). The gained value is floor(source·coefficient/4096), kept at full width.
- R5: Mode 1: speaker = 2·gM, both headphones muted. Mode 2: speaker shut down, both headphones = gM.
- R6: Mode 3: speaker = gL+gR, both headphones muted. Mode 4: speaker shut down, right headphone = gR, left headphone = gL.
- R7: Mode 5: speaker = gL+gR+2·gM, both headphones muted. Mode 6: speaker shut down, right headphone = gR+gM, left headphone = gL+gM.
- R8: Mode 7: speaker = gL+gR, right headphone = gR, left headphone = gL, none muted or shut down. Mode 0: all three outputs shut down. Both headphones always share the same mute and shutdown state.
- R9: Each active output is its full-width sum clipped to [-32768, 32767], with no wrap-around.
- R10: A muted output gives data 0 with mute=1 and shutdown=0. A shut-down output gives data 0 with shutdown=1 and mute=0. An active output has both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe; samples and settings are taken when high |
| in_a_l | input | 16 | Pair A left sample, signed |
| in_a_r | input | 16 | Pair A right sample, signed |
| in_b_l | input | 16 | Pair B left sample, signed |
| in_b_r | input | 16 | Pair B right sample, signed |
| in_mono | input | 16 | Mono sample, signed |
| sel_a | input | 1 | Include pair A in the stereo source |
| sel_b | input | 1 | Include pair B in the stereo source |
| diff_en | input | 1 | Use A minus B as the stereo source |
| gain_l | input | 5 | Left gain code |
| gain_r | input | 5 | Right gain code |
| gain_m | input | 5 | Mono gain code |
| mode | input | 3 | Routing mode |
| out_valid | output | 1 | Output strobe |
| spk_data | output | 16 | Speaker sample, signed |
| spk_mute | output | 1 | Speaker muted |
| spk_off | output | 1 | Speaker shut down |
| hpl_data | output | 16 | Left headphone sample, signed |
| hpl_mute | output | 1 | Left headphone muted |
| hpl_off | output | 1 | Left headphone shut down |
| hpr_data | output | 16 | Right headphone sample, signed |
| hpr_mute | output | 1 | Right headphone muted |
| hpr_off | output | 1 | Right headphone shut down |

## Verification
Every mode is driven with distinct values on the left, right and mono sources, so a swapped or missing term changes the result. Unequal gain codes per channel show whether each gain reaches the correct path. All four selector combinations are applied with unlike A and B values, and the difference mode is applied with both selects set, which separates sum, difference, single-pair and zero sources. Large inputs of both signs at +18 dB exercise clipping at both rails. Gain codes 0, 19 and 31 are applied to one known sample to pin the ends and the unity point of the staircase. Settings are changed without a strobe to show that no output moves.

// File: rtl/arm_pkg.sv
package arm_pkg;
   localparam int CODE_W    = 5;
   localparam int COEF_W    = 16;
   localparam int COEF_FRAC = 12;
   localparam int MODE_W    = 3;

   typedef enum logic [1:0] {PATH_OFF, PATH_MUTE, PATH_ON} path_state_e;

   // Q4.12 linear coefficients of the dB staircase
   function automatic logic [COEF_W-1:0] gain_coef(input logic [CODE_W-1:0] code);
      logic [COEF_W-1:0] c;
      case (code)
         5'd0:  c = 16'd4;     5'd1:  c = 16'd16;    5'd2:  c = 16'd39;    5'd3:  c = 16'd77;
         5'd4:  c = 16'd130;   5'd5:  c = 16'd183;   5'd6:  c = 16'd258;   5'd7:  c = 16'd365;
         5'd8:  c = 16'd516;   5'd9:  c = 16'd728;   5'd10: c = 16'd866;   5'd11: c = 16'd1029;
         5'd12: c = 16'd1223;  5'd13: c = 16'd1453;  5'd14: c = 16'd1727;  5'd15: c = 16'd2053;
         5'd16: c = 16'd2440;  5'd17: c = 16'd2900;  5'd18: c = 16'd3446;  5'd19: c = 16'd4096;
         5'd20: c = 16'd4868;  5'd21: c = 16'd5786;  5'd22: c = 16'd6876;  5'd23: c = 16'd8173;
         5'd24: c = 16'd9713;  5'd25: c = 16'd11544; 5'd26: c = 16'd13720; 5'd27: c = 16'd16306;
         5'd28: c = 16'd19380; 5'd29: c = 16'd23034; 5'd30: c = 16'd27375; default: c = 16'd32536;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/arm_src_sel.sv
module arm_src_sel #(
   parameter int SW = 16
) (
   input  logic signed [SW-1:0] a,
   input  logic signed [SW-1:0] b,
   input  logic                 sel_a,
   input  logic                 sel_b,
   input  logic                 diff_en,
   output logic signed [SW:0]   src
);
   logic signed [SW:0] a_x, b_x;
   assign a_x = $signed({a[SW-1], a});
   assign b_x = $signed({b[SW-1], b});

   always_comb begin
      if (diff_en) begin
         src = a_x - b_x;
      end else begin
         case ({sel_a, sel_b})
            2'b10:   src = a_x;
            2'b01:   src = b_x;
            2'b11:   src = a_x + b_x;
            default: src = '0;
         endcase
      end
   end
endmodule

// File: rtl/arm_gain.sv
module arm_gain #(
   parameter int SRC_W = 17,
   parameter int GW    = SRC_W + arm_pkg::COEF_W + 1 - arm_pkg::COEF_FRAC
) (
   input  logic signed [SRC_W-1:0]           src,
   input  logic        [arm_pkg::CODE_W-1:0] code,
   output logic signed [GW-1:0]              gained
);
   localparam int PW = SRC_W + arm_pkg::COEF_W + 1;

   logic [arm_pkg::COEF_W-1:0] coef;
   logic signed [PW-1:0]       prod;

   assign coef   = arm_pkg::gain_coef(code);
   assign prod   = PW'(src) * PW'($signed({1'b0, coef}));
   assign gained = GW'(prod >>> arm_pkg::COEF_FRAC);
endmodule

// File: rtl/arm_route.sv
module arm_route #(
   parameter int SW = 16,
   parameter int GW = 22
) (
   input  logic [arm_pkg::MODE_W-1:0] mode,
   input  logic signed [GW-1:0]       g_l,
   input  logic signed [GW-1:0]       g_r,
   input  logic signed [GW-1:0]       g_m,
   output logic signed [SW-1:0]       spk_val,
   output logic signed [SW-1:0]       hpl_val,
   output logic signed [SW-1:0]       hpr_val,
   output arm_pkg::path_state_e       spk_st,
   output arm_pkg::path_state_e       hp_st
);
   import arm_pkg::*;
   localparam int MIX_W = GW + 3;
   localparam logic signed [MIX_W-1:0] HI = {{(MIX_W-SW+1){1'b0}}, {(SW-1){1'b1}}};
   localparam logic signed [MIX_W-1:0] LO = ~HI;

   function automatic logic signed [SW-1:0] clip(input logic signed [MIX_W-1:0] x);
      if (x > HI)      return HI[SW-1:0];
      else if (x < LO) return LO[SW-1:0];
      else             return x[SW-1:0];
   endfunction

   logic signed [MIX_W-1:0] m_l, m_r, m_m, spk_sum, hpl_sum, hpr_sum;
   assign m_l = MIX_W'(g_l);
   assign m_r = MIX_W'(g_r);
   assign m_m = MIX_W'(g_m);

   always_comb begin
      spk_sum = '0;
      hpl_sum = '0;
      hpr_sum = '0;
      spk_st  = PATH_OFF;
      hp_st   = PATH_OFF;
      case (mode)
         3'd1: begin spk_st = PATH_ON;  hp_st = PATH_MUTE; spk_sum = m_m <<< 1; end
         3'd2: begin spk_st = PATH_OFF; hp_st = PATH_ON;   hpl_sum = m_m; hpr_sum = m_m; end
         3'd3: begin spk_st = PATH_ON;  hp_st = PATH_MUTE; spk_sum = m_l + m_r; end
         3'd4: begin spk_st = PATH_OFF; hp_st = PATH_ON;   hpl_sum = m_l; hpr_sum = m_r; end
         3'd5: begin spk_st = PATH_ON;  hp_st = PATH_MUTE; spk_sum = m_l + m_r + (m_m <<< 1); end
         3'd6: begin spk_st = PATH_OFF; hp_st = PATH_ON;   hpl_sum = m_l + m_m; hpr_sum = m_r + m_m; end
         3'd7: begin
            spk_st = PATH_ON; hp_st = PATH_ON;
            spk_sum = m_l + m_r; hpl_sum = m_l; hpr_sum = m_r;
         end
         default: ;
      endcase
   end

   assign spk_val = (spk_st == PATH_ON) ? clip(spk_sum) : '0;
   assign hpl_val = (hp_st  == PATH_ON) ? clip(hpl_sum) : '0;
   assign hpr_val = (hp_st  == PATH_ON) ? clip(hpr_sum) : '0;
endmodule

// File: rtl/audio_route_mixer.sv
module audio_route_mixer #(
   parameter int SAMPLE_W = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid,
   input  logic signed [SAMPLE_W-1:0]         in_a_l,
   input  logic signed [SAMPLE_W-1:0]         in_a_r,
   input  logic signed [SAMPLE_W-1:0]         in_b_l,
   input  logic signed [SAMPLE_W-1:0]         in_b_r,
   input  logic signed [SAMPLE_W-1:0]         in_mono,
   input  logic                               sel_a,
   input  logic                               sel_b,
   input  logic                               diff_en,
   input  logic        [arm_pkg::CODE_W-1:0]  gain_l,
   input  logic        [arm_pkg::CODE_W-1:0]  gain_r,
   input  logic        [arm_pkg::CODE_W-1:0]  gain_m,
   input  logic        [arm_pkg::MODE_W-1:0]  mode,
   output logic                               out_valid,
   output logic signed [SAMPLE_W-1:0]         spk_data,
   output logic                               spk_mute,
   output logic                               spk_off,
   output logic signed [SAMPLE_W-1:0]         hpl_data,
   output logic                               hpl_mute,
   output logic                               hpl_off,
   output logic signed [SAMPLE_W-1:0]         hpr_data,
   output logic                               hpr_mute,
   output logic                               hpr_off
);
   import arm_pkg::*;
   localparam int SRC_W = SAMPLE_W + 1;
   localparam int GW    = SRC_W + COEF_W + 1 - COEF_FRAC;
   localparam int NCH   = 3;

   if (SAMPLE_W < 8 || SAMPLE_W > 32) begin : g_bad_width
      $error("audio_route_mixer: SAMPLE_W out of range");
   end

   // stereo source selection, one selector per side (0 = left, 1 = right)
   logic signed [SAMPLE_W-1:0] side_a [2];
   logic signed [SAMPLE_W-1:0] side_b [2];
   logic signed [SRC_W-1:0]    side_src [2];
   assign side_a[0] = in_a_l;
   assign side_a[1] = in_a_r;
   assign side_b[0] = in_b_l;
   assign side_b[1] = in_b_r;

   for (genvar s = 0; s < 2; s++) begin : g_side
      arm_src_sel #(.SW(SAMPLE_W)) u_sel (
         .a(side_a[s]), .b(side_b[s]), .sel_a(sel_a), .sel_b(sel_b),
         .diff_en(diff_en), .src(side_src[s])
      );
   end

   // gain stages: 0 = left, 1 = right, 2 = mono
   logic signed [SRC_W-1:0]  ch_src  [NCH];
   logic        [CODE_W-1:0] ch_code [NCH];
   logic signed [GW-1:0]     ch_gain [NCH];
   assign ch_src[0]  = side_src[0];
   assign ch_src[1]  = side_src[1];
   assign ch_src[2]  = $signed({in_mono[SAMPLE_W-1], in_mono});
   assign ch_code[0] = gain_l;
   assign ch_code[1] = gain_r;
   assign ch_code[2] = gain_m;

   for (genvar k = 0; k < NCH; k++) begin : g_gain
      arm_gain #(.SRC_W(SRC_W), .GW(GW)) u_gain (
         .src(ch_src[k]), .code(ch_code[k]), .gained(ch_gain[k])
      );
   end

   logic signed [SAMPLE_W-1:0] spk_v, hpl_v, hpr_v;
   path_state_e                spk_st, hp_st;

   arm_route #(.SW(SAMPLE_W), .GW(GW)) u_route (
      .mode(mode), .g_l(ch_gain[0]), .g_r(ch_gain[1]), .g_m(ch_gain[2]),
      .spk_val(spk_v), .hpl_val(hpl_v), .hpr_val(hpr_v),
      .spk_st(spk_st), .hp_st(hp_st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         spk_data  <= '0;  hpl_data <= '0;  hpr_data <= '0;
         spk_off   <= 1'b1; hpl_off <= 1'b1; hpr_off <= 1'b1;
         spk_mute  <= 1'b0; hpl_mute <= 1'b0; hpr_mute <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            spk_data <= spk_v;
            hpl_data <= hpl_v;
            hpr_data <= hpr_v;
            spk_off  <= (spk_st == PATH_OFF);
            spk_mute <= (spk_st == PATH_MUTE);
            hpl_off  <= (hp_st == PATH_OFF);
            hpl_mute <= (hp_st == PATH_MUTE);
            hpr_off  <= (hp_st == PATH_OFF);
            hpr_mute <= (hp_st == PATH_MUTE);
         end
      end
   end

   a_r2_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> ($stable(spk_data) && $stable(hpl_data) && $stable(hpr_data)
                            && $stable(spk_off) && $stable(hpl_mute)));

   a_r10_spk_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_off || spk_mute) |-> (spk_data == '0 && !(spk_off && spk_mute)));

   a_r10_hp_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (hpl_off || hpl_mute) |-> (hpl_data == '0 && !(hpl_off && hpl_mute)));

   a_r8_hp_shared_state: assert property (@(posedge clk) disable iff (!rst_n)
      (hpl_off == hpr_off) && (hpl_mute == hpr_mute));
endmodule

// File: tb/test_audio_route_mixer.sv
module test_audio_route_mixer;
   typedef struct packed {
      logic [2:0]  md;
      logic        sa, sb, df;
      logic [4:0]  gl, gr, gm;
      logic [15:0] al, ar, bl, br, mo;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd1000, 16'd2000, 16'd300, 16'd400, 16'd500},
      '{3'd1, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd1000, 16'd2000, 16'd300, 16'd400, 16'd1000},
      '{3'd2, 1'b1, 1'b0, 1'b0, 5'd10, 5'd22, 5'd15, 16'd1000, 16'd2000, 16'd300, 16'd400, 16'd4000},
      '{3'd3, 1'b1, 1'b0, 1'b0, 5'd19, 5'd21, 5'd5,  16'd100,  16'd200,  16'd7,   16'd9,   16'd3000},
      '{3'd4, 1'b0, 1'b1, 1'b0, 5'd31, 5'd0,  5'd19, 16'd50,   16'd60,   16'd1000,16'd20000,16'd11},
      '{3'd5, 1'b1, 1'b1, 1'b0, 5'd18, 5'd20, 5'd17, 16'd1200, 16'hFC18, 16'd800, 16'd500, 16'hF830},
      '{3'd6, 1'b0, 1'b0, 1'b1, 5'd25, 5'd13, 5'd7,  16'd900,  16'd100,  16'd300, 16'd2100, 16'd700},
      '{3'd7, 1'b1, 1'b0, 1'b0, 5'd16, 5'd26, 5'd19, 16'd3333, 16'hF000, 16'd1,   16'd2,   16'd55},
      '{3'd7, 1'b0, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd3333, 16'd4444, 16'd555, 16'd666, 16'd77},
      '{3'd4, 1'b1, 1'b1, 1'b1, 5'd19, 5'd19, 5'd19, 16'd5000, 16'd100,  16'd2000,16'd900, 16'd0},
      '{3'd4, 1'b1, 1'b0, 1'b0, 5'd0,  5'd1,  5'd19, 16'd32767,16'h8000, 16'd0,   16'd0,   16'd0},
      '{3'd6, 1'b0, 1'b1, 1'b0, 5'd23, 5'd24, 5'd27, 16'd0,    16'd0,    16'hF060,16'hE890,16'hFF00}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_a_l = '0, in_a_r = '0, in_b_l = '0, in_b_r = '0, in_mono = '0;
   logic sel_a = 1'b0, sel_b = 1'b0, diff_en = 1'b0;
   logic [4:0] gain_l = '0, gain_r = '0, gain_m = '0;
   logic [2:0] mode = '0;
   logic out_valid;
   logic signed [15:0] spk_data, hpl_data, hpr_data;
   logic spk_mute, spk_off, hpl_mute, hpl_off, hpr_mute, hpr_off;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   longint e_spk, e_hpl, e_hpr;
   int     e_spk_st, e_hp_st;   // 0 shut down, 1 muted, 2 active

   always #5 clk = ~clk;

   audio_route_mixer i_audio_route_mixer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_a_l(in_a_l), .in_a_r(in_a_r), .in_b_l(in_b_l), .in_b_r(in_b_r), .in_mono(in_mono),
      .sel_a(sel_a), .sel_b(sel_b), .diff_en(diff_en),
      .gain_l(gain_l), .gain_r(gain_r), .gain_m(gain_m), .mode(mode),
      .out_valid(out_valid),
      .spk_data(spk_data), .spk_mute(spk_mute), .spk_off(spk_off),
      .hpl_data(hpl_data), .hpl_mute(hpl_mute), .hpl_off(hpl_off),
      .hpr_data(hpr_data), .hpr_mute(hpr_mute), .hpr_off(hpr_off)
   );

   function automatic longint coef_of(input int code);
      real db;
      if (code == 0)      db = -59.5;
      else if (code == 1) db = -48.0;
      else if (code == 2) db = -40.5;
      else if (code == 3) db = -34.5;
      else if (code <= 9) db = -30.0 + 3.0 * (code - 4);
      else                db = -15.0 + 1.5 * (code - 9);
      return longint'($rtoi($floor(4096.0 * $pow(10.0, db / 20.0) + 0.5)));
   endfunction

   function automatic longint gained(input longint src, input int code);
      longint p;
      p = src * coef_of(code);
      return p >>> 12;
   endfunction

   function automatic longint clip(input longint x);
      if (x > 32767)  return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   function automatic longint pick(input vec_t v, input longint a, input longint b);
      if (v.df) return a - b;
      case ({v.sa, v.sb})
         2'b10:   return a;
         2'b01:   return b;
         2'b11:   return a + b;
         default: return 0;
      endcase
   endfunction

   task automatic model(input vec_t v);
      longint gl, gr, gm, s, l, r;
      gl = gained(pick(v, longint'($signed(v.al)), longint'($signed(v.bl))), int'(v.gl));
      gr = gained(pick(v, longint'($signed(v.ar)), longint'($signed(v.br))), int'(v.gr));
      gm = gained(longint'($signed(v.mo)), int'(v.gm));
      s = 0; l = 0; r = 0;
      case (v.md)
         3'd1: begin e_spk_st = 2; e_hp_st = 1; s = 2 * gm; end
         3'd2: begin e_spk_st = 0; e_hp_st = 2; l = gm; r = gm; end
         3'd3: begin e_spk_st = 2; e_hp_st = 1; s = gl + gr; end
         3'd4: begin e_spk_st = 0; e_hp_st = 2; l = gl; r = gr; end
         3'd5: begin e_spk_st = 2; e_hp_st = 1; s = gl + gr + 2 * gm; end
         3'd6: begin e_spk_st = 0; e_hp_st = 2; l = gl + gm; r = gr + gm; end
         3'd7: begin e_spk_st = 2; e_hp_st = 2; s = gl + gr; l = gl; r = gr; end
         default: begin e_spk_st = 0; e_hp_st = 0; end
      endcase
      e_spk = (e_spk_st == 2) ? clip(s) : 0;
      e_hpl = (e_hp_st == 2) ? clip(l) : 0;
      e_hpr = (e_hp_st == 2) ? clip(r) : 0;
   endtask

   task automatic check_out(input string req);
      bit ok;
      ok = (longint'(spk_data) == e_spk) && (longint'(hpl_data) == e_hpl) && (longint'(hpr_data) == e_hpr)
        && (spk_off == (e_spk_st == 0)) && (spk_mute == (e_spk_st == 1))
        && (hpl_off == (e_hp_st == 0))  && (hpl_mute == (e_hp_st == 1))
        && (hpr_off == (e_hp_st == 0))  && (hpr_mute == (e_hp_st == 1));
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual spk=%0d hpl=%0d hpr=%0d off=%b%b%b mute=%b%b%b expected spk=%0d hpl=%0d hpr=%0d spk_st=%0d hp_st=%0d",
                  req, spk_data, hpl_data, hpr_data, spk_off, hpl_off, hpr_off,
                  spk_mute, hpl_mute, hpr_mute, e_spk, e_hpl, e_hpr, e_spk_st, e_hp_st);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic put(input vec_t v);
      mode = v.md; sel_a = v.sa; sel_b = v.sb; diff_en = v.df;
      gain_l = v.gl; gain_r = v.gr; gain_m = v.gm;
      in_a_l = v.al; in_a_r = v.ar; in_b_l = v.bl; in_b_r = v.br; in_mono = v.mo;
   endtask

   // drive at the falling edge, capture at the rising edge, check at the next falling edge
   task automatic apply(input vec_t v);
      put(v);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      model(v);
   endtask

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd1, 3'd2: return "R5";
         3'd3, 3'd4: return "R6";
         3'd5, 3'd6: return "R7";
         default:    return "R8";
      endcase
   endfunction

   function automatic vec_t mk(input logic [2:0] md, input logic sa, input logic sb, input logic df,
                               input logic [4:0] gl, input logic [4:0] gr, input logic [4:0] gm,
                               input logic [15:0] al, input logic [15:0] ar, input logic [15:0] bl,
                               input logic [15:0] br, input logic [15:0] mo);
      vec_t v;
      v.md = md; v.sa = sa; v.sb = sb; v.df = df; v.gl = gl; v.gr = gr; v.gm = gm;
      v.al = al; v.ar = ar; v.bl = bl; v.br = br; v.mo = mo;
      return v;
   endfunction

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: state held during reset
      e_spk = 0; e_hpl = 0; e_hpr = 0; e_spk_st = 0; e_hp_st = 0;
      check_out("R1");
      check_bit("R1", out_valid, 1'b0);
      rst_n = 1'b1;
      // R1/R2: settings change with no strobe, outputs stay in reset state
      put(VECS[7]);
      repeat (3) @(negedge clk);
      check_out("R1");
      check_bit("R2", out_valid, 1'b0);

      // main vector table
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         check_bit("R2", out_valid, 1'b1);
         check_out(tag_of(VECS[i].md));
      end

      // R2: strobe drops, outputs hold while every setting moves
      @(negedge clk);
      check_bit("R2", out_valid, 1'b0);
      put(mk(3'd1, 1'b1, 1'b1, 1'b0, 5'd31, 5'd31, 5'd31, 16'd9, 16'd9, 16'd9, 16'd9, 16'd9));
      repeat (2) @(negedge clk);
      check_out("R2");

      // R3: each selector combination, tested through mode 4 at unity gain
      apply(mk(3'd4, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd111, 16'd222, 16'd1000, 16'd3000, 16'd0));
      check_out("R3");
      apply(mk(3'd4, 1'b0, 1'b1, 1'b0, 5'd19, 5'd19, 5'd19, 16'd111, 16'd222, 16'd1000, 16'd3000, 16'd0));
      check_out("R3");
      apply(mk(3'd4, 1'b1, 1'b1, 1'b0, 5'd19, 5'd19, 5'd19, 16'd111, 16'd222, 16'd1000, 16'd3000, 16'd0));
      check_out("R3");
      apply(mk(3'd4, 1'b0, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd111, 16'd222, 16'd1000, 16'd3000, 16'd0));
      check_out("R3");
      apply(mk(3'd4, 1'b1, 1'b1, 1'b1, 5'd19, 5'd19, 5'd19, 16'd111, 16'd222, 16'd1000, 16'd3000, 16'd0));
      check_out("R3");

      // R4: staircase ends and unity point on one sample
      apply(mk(3'd2, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd20000));
      check_out("R4");
      apply(mk(3'd2, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd19, 16'd0, 16'd0, 16'd0, 16'd0, 16'd20000));
      check_out("R4");
      apply(mk(3'd2, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd31, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3000));
      check_out("R4");
      apply(mk(3'd2, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd9, 16'd0, 16'd0, 16'd0, 16'd0, 16'hFFFD));
      check_out("R4");

      // R9: clipping at both rails
      apply(mk(3'd5, 1'b1, 1'b0, 1'b0, 5'd31, 5'd31, 5'd31, 16'd30000, 16'd30000, 16'd0, 16'd0, 16'd30000));
      check_out("R9");
      check_bit("R9", spk_data == 16'sd32767, 1'b1);
      apply(mk(3'd1, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd31, 16'd0, 16'd0, 16'd0, 16'd0, 16'h8000));
      check_out("R9");
      check_bit("R9", spk_data == -16'sd32768, 1'b1);
      apply(mk(3'd6, 1'b1, 1'b0, 1'b0, 5'd31, 5'd31, 5'd31, 16'h9000, 16'd28000, 16'd0, 16'd0, 16'h9000));
      check_out("R9");

      // R10: flag encodings for mute, shutdown and active
      apply(mk(3'd3, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd10, 16'd20, 16'd0, 16'd0, 16'd0));
      check_bit("R10", hpl_mute && !hpl_off && hpl_data == 0, 1'b1);
      check_bit("R10", !spk_mute && !spk_off && spk_data == 16'sd30, 1'b1);
      apply(mk(3'd2, 1'b1, 1'b0, 1'b0, 5'd19, 5'd19, 5'd19, 16'd10, 16'd20, 16'd0, 16'd0, 16'd5));
      check_bit("R10", spk_off && !spk_mute && spk_data == 0, 1'b1);
      // R8: back to mode 0 shuts every output down
      apply(VECS[0]);
      check_out("R8");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule